// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This unit sits beside a simple in-order core and watches three streams: instruction fetches, instruction retirements and data accesses. Software loads a break address, an address mask, a break data value and a control word through a small write port. When the selected condition is met, the unit raises a one-cycle break request. With the request it supplies the program counter value that the core saves before it enters its break handler.

The saved value depends on the kind of break:

- **Before execution (fetch match):** the saved value is the matching instruction itself. If that instruction sits in a delay slot, the saved value is the delayed branch that owns the slot.
- **After execution (retire match):** the saved value is the next instruction. If the matching instruction is a delayed branch, the unit first waits for the slot instruction to retire and then saves the branch destination.
- **Data access, address only:** the access completes, and the break is taken at the next retirement.
- **Data access, address and data:** the break is imprecise and lands one retirement later.

The three observed streams carry a valid flag and no ready. The unit accepts every beat in the cycle it is presented, so the core never sees back-pressure. A request holds the unit locked until the core pulses `brk_ack`.

Top module: `brk_match_unit`

## Requirements
- R1: After reset every compare register and the control word are zero, so the unit is disabled, `brk_req` is 0 and `brk_pc` is 0. No stimulus raises a request while the enable bit is 0.
- R2: `cfg_we` writes `cfg_wdata` to the register chosen by `cfg_sel`: 0 = break address, 1 = address mask, 2 = break data, 3 = control. An address matches when it equals the break address in every bit whose mask bit is 0. Bits whose mask bit is 1 are ignored.
- R3: Control kind 0 (before execution): a matching fetch with `if_slot`=0 gives `brk_req`=1 in the cycle after the fetch, with `brk_pc` equal to the fetch address.
- R4: Kind 0 with `if_slot`=1: `brk_pc` is the fetch address minus `INSN_BYTES`, which is the address of the delayed branch that owns the slot.
- R5: Control kind 1 (after execution): a matching retirement with `rt_dbr`=0 gives a request in the next cycle, with `brk_pc` = `rt_next`.
- R6: Kind 1 on a matching retirement with `rt_dbr`=1: the unit keeps `rt_target` and waits. The request follows the next retirement (the slot instruction), with `brk_pc` = the kept target.
- R7: Control kind 2 (data address only): `da_data` is ignored. The request follows the first retirement in the same cycle as the matching access or later, with `brk_pc` = that retirement's `rt_next`.
- R8: Control kind 3 (address and data): the access must also match the break data in every bit. The request follows the first retirement strictly after the access cycle, with `brk_pc` = that retirement's `rt_next`.
- R9: `brk_req` is high for exactly one cycle per break. Matches are ignored from the break until the end of the cycle in which `brk_ack` is high, and that cycle is included.
- R10: The control word holds the enable in bit 0 and the kind in bits 2:1. Any control write clears a pending kind 1, 2 or 3 break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (R2) |
| cfg_wdata | input | CW | Write data, the wider of AW and DW |
| if_valid | input | 1 | Fetch beat valid |
| if_addr | input | AW | Fetch address |
| if_slot | input | 1 | Fetched instruction sits in a delay slot |
| rt_valid | input | 1 | Retirement beat valid |
| rt_addr | input | AW | Address of the retiring instruction |
| rt_dbr | input | 1 | Retiring instruction is a delayed branch |
| rt_next | input | AW | Address of the next instruction to execute |
| rt_target | input | AW | Destination of a retiring delayed branch |
| da_valid | input | 1 | Data access valid |
| da_addr | input | AW | Data access address |
| da_data | input | DW | Data access value |
| brk_ack | input | 1 | Core acknowledges the break |
| brk_req | output | 1 | One-cycle break request |
| brk_pc | output | AW | Program counter value to save |

## Verification
Two events can land in one cycle: a new match and the acknowledgement that releases the lock. The bench drives a matching fetch in the same cycle as `brk_ack` and expects no request. It then repeats the fetch alone and expects one. A second collision comes from the data paths: a matching access in the same cycle as a retirement. That cycle must break in address-only mode and must not break in address-plus-data mode. Each case is judged by comparing `brk_req` and `brk_pc` one cycle later against values the bench computes itself.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    BK_PRE  = 2'd0,
    BK_POST = 2'd1,
    BK_DADR = 2'd2,
    BK_DDAT = 2'd3
  } bk_kind_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;
endpackage

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int W = 32,
  parameter bit MASKED = 1'b1
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] ref_val,
  input  logic [W-1:0] dont_care,
  output logic         eq
);
  logic [W-1:0] diff;
  assign diff = val ^ ref_val;
  generate
    if (MASKED) begin : g_masked
      assign eq = ~|(diff & ~dont_care);
    end else begin : g_exact
      logic [W-1:0] unused_dc;
      assign unused_dc = dont_care;
      assign eq = ~|diff;
    end
  endgenerate
endmodule

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [CW-1:0] wdata,
  output logic [AW-1:0] brk_addr,
  output logic [AW-1:0] brk_mask,
  output logic [DW-1:0] brk_data,
  output logic          en,
  output bk_kind_e      kind,
  output logic          ctl_wr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_addr <= '0;
      brk_mask <= '0;
      brk_data <= '0;
      en       <= 1'b0;
      kind     <= BK_PRE;
    end else if (we) begin
      case (sel)
        SEL_ADDR: brk_addr <= wdata[AW-1:0];
        SEL_MASK: brk_mask <= wdata[AW-1:0];
        SEL_DATA: brk_data <= wdata[DW-1:0];
        default: begin
          en   <= wdata[0];
          kind <= bk_kind_e'(wdata[2:1]);
        end
      endcase
    end
  end

  assign ctl_wr = we && (sel == SEL_CTRL);
endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int INSN_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  bk_kind_e      kind,
  input  logic          ctl_wr,
  input  logic          if_valid,
  input  logic [AW-1:0] if_addr,
  input  logic          if_slot,
  input  logic          hit_if,
  input  logic          rt_valid,
  input  logic          rt_dbr,
  input  logic [AW-1:0] rt_next,
  input  logic [AW-1:0] rt_target,
  input  logic          hit_rt,
  input  logic          da_valid,
  input  logic          hit_da,
  input  logic          hit_dd,
  input  logic          ack,
  output logic          req,
  output logic [AW-1:0] pc,
  output logic          locked
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  logic          lock_q, slot_q, da_q, dd_q;
  logic [AW-1:0] tgt_q;
  logic          fire, set_slot, set_da, set_dd, flush;
  logic [AW-1:0] pc_n;
  logic          da_hit_now;

  assign da_hit_now = da_valid && hit_da;

  always_comb begin
    fire     = 1'b0;
    pc_n     = '0;
    set_slot = 1'b0;
    set_da   = 1'b0;
    set_dd   = 1'b0;
    if (en && !lock_q) begin
      case (kind)
        BK_PRE: begin
          if (if_valid && hit_if) begin
            fire = 1'b1;
            pc_n = if_slot ? (if_addr - STEP) : if_addr;
          end
        end
        BK_POST: begin
          if (slot_q && rt_valid) begin
            fire = 1'b1;
            pc_n = tgt_q;
          end else if (rt_valid && hit_rt) begin
            if (rt_dbr) set_slot = 1'b1;
            else begin
              fire = 1'b1;
              pc_n = rt_next;
            end
          end
        end
        BK_DADR: begin
          if (rt_valid && (da_q || da_hit_now)) begin
            fire = 1'b1;
            pc_n = rt_next;
          end else if (da_hit_now) set_da = 1'b1;
        end
        default: begin
          if (rt_valid && dd_q) begin
            fire = 1'b1;
            pc_n = rt_next;
          end else if (da_hit_now && hit_dd) set_dd = 1'b1;
        end
      endcase
    end
  end

  assign flush = fire || ctl_wr || !en || lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req    <= 1'b0;
      pc     <= '0;
      lock_q <= 1'b0;
      slot_q <= 1'b0;
      da_q   <= 1'b0;
      dd_q   <= 1'b0;
      tgt_q  <= '0;
    end else begin
      req <= fire;
      if (fire) pc <= pc_n;
      if (fire) lock_q <= 1'b1;
      else if (ack) lock_q <= 1'b0;
      slot_q <= !flush && (slot_q || set_slot);
      da_q   <= !flush && (da_q || set_da);
      dd_q   <= !flush && (dd_q || set_dd);
      if (set_slot) tgt_q <= rt_target;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int INSN_BYTES = 2,
  localparam int CW = (AW > DW) ? AW : DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          if_valid,
  input  logic [AW-1:0] if_addr,
  input  logic          if_slot,
  input  logic          rt_valid,
  input  logic [AW-1:0] rt_addr,
  input  logic          rt_dbr,
  input  logic [AW-1:0] rt_next,
  input  logic [AW-1:0] rt_target,
  input  logic          da_valid,
  input  logic [AW-1:0] da_addr,
  input  logic [DW-1:0] da_data,
  input  logic          brk_ack,
  output logic          brk_req,
  output logic [AW-1:0] brk_pc
);
  logic [AW-1:0] ba_w, bm_w;
  logic [DW-1:0] bd_w;
  logic          en_w, ctl_wr_w, lock_w;
  bk_kind_e      kind_w;
  logic          hit_if, hit_rt, hit_da, hit_dd;

  brk_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .brk_addr(ba_w), .brk_mask(bm_w), .brk_data(bd_w),
    .en(en_w), .kind(kind_w), .ctl_wr(ctl_wr_w)
  );

  brk_cmp #(.W(AW), .MASKED(1'b1)) u_cmp_if (
    .val(if_addr), .ref_val(ba_w), .dont_care(bm_w), .eq(hit_if));
  brk_cmp #(.W(AW), .MASKED(1'b1)) u_cmp_rt (
    .val(rt_addr), .ref_val(ba_w), .dont_care(bm_w), .eq(hit_rt));
  brk_cmp #(.W(AW), .MASKED(1'b1)) u_cmp_da (
    .val(da_addr), .ref_val(ba_w), .dont_care(bm_w), .eq(hit_da));
  brk_cmp #(.W(DW), .MASKED(1'b0)) u_cmp_dd (
    .val(da_data), .ref_val(bd_w), .dont_care({DW{1'b0}}), .eq(hit_dd));

  brk_seq #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en_w), .kind(kind_w), .ctl_wr(ctl_wr_w),
    .if_valid(if_valid), .if_addr(if_addr), .if_slot(if_slot), .hit_if(hit_if),
    .rt_valid(rt_valid), .rt_dbr(rt_dbr), .rt_next(rt_next),
    .rt_target(rt_target), .hit_rt(hit_rt),
    .da_valid(da_valid), .hit_da(hit_da), .hit_dd(hit_dd),
    .ack(brk_ack), .req(brk_req), .pc(brk_pc), .locked(lock_w)
  );
endmodule

// File: rtl/brk_match_chk.sv
module brk_match_chk
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int INSN_BYTES = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input bk_kind_e      kind,
  input logic          locked,
  input logic [AW-1:0] ba,
  input logic [AW-1:0] bm,
  input logic          if_valid,
  input logic [AW-1:0] if_addr,
  input logic          if_slot,
  input logic          brk_ack,
  input logic          brk_req,
  input logic [AW-1:0] brk_pc
);
  logic fetch_hit;
  assign fetch_hit = if_valid && (((if_addr ^ ba) & ~bm) == '0);

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !brk_req);

  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);

  // R9
  ack_cycle_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && brk_ack) |=> !brk_req);

  // R9
  req_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> locked);

  // R3
  pre_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == BK_PRE && !locked && fetch_hit && !if_slot)
      |=> (brk_req && brk_pc == $past(if_addr)));

  // R4
  pre_slot_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == BK_PRE && !locked && fetch_hit && if_slot)
      |=> (brk_req && brk_pc == $past(if_addr) - AW'(INSN_BYTES)));
endmodule

bind brk_match_unit brk_match_chk #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_w), .kind(kind_w), .locked(lock_w),
  .ba(ba_w), .bm(bm_w), .if_valid(if_valid), .if_addr(if_addr),
  .if_slot(if_slot), .brk_ack(brk_ack), .brk_req(brk_req), .brk_pc(brk_pc)
);

// File: tb/brk_match_unit_test.sv
module brk_match_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        if_valid = 1'b0, if_slot = 1'b0;
  logic [31:0] if_addr = '0;
  logic        rt_valid = 1'b0, rt_dbr = 1'b0;
  logic [31:0] rt_addr = '0, rt_next = '0, rt_target = '0;
  logic        da_valid = 1'b0;
  logic [31:0] da_addr = '0, da_data = '0;
  logic        brk_ack = 1'b0;
  logic        brk_req;
  logic [31:0] brk_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  brk_match_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .if_valid(if_valid), .if_addr(if_addr),
    .if_slot(if_slot), .rt_valid(rt_valid), .rt_addr(rt_addr),
    .rt_dbr(rt_dbr), .rt_next(rt_next), .rt_target(rt_target),
    .da_valid(da_valid), .da_addr(da_addr), .da_data(da_data),
    .brk_ack(brk_ack), .brk_req(brk_req), .brk_pc(brk_pc)
  );

  function automatic bit pre_hit(input logic [31:0] a, input logic [31:0] base,
                                 input logic [31:0] m);
    return ((a ^ base) & ~m) == 32'd0;
  endfunction

  function automatic logic [31:0] pre_pc(input logic [31:0] a, input bit slot);
    return slot ? a - 32'd2 : a;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_brk(input bit req, input logic [31:0] pc, input string tag);
    check(brk_req == req, {tag, " req"}, {31'd0, brk_req}, {31'd0, req});
    if (req) check(brk_pc == pc, {tag, " pc"}, brk_pc, pc);
  endtask

  task automatic cyc();
    @(negedge clk);
    cfg_we = 1'b0; if_valid = 1'b0; if_slot = 1'b0;
    rt_valid = 1'b0; rt_dbr = 1'b0; da_valid = 1'b0; brk_ack = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d; cyc();
  endtask

  task automatic fetch(input logic [31:0] a, input bit s);
    if_valid = 1'b1; if_addr = a; if_slot = s;
  endtask

  task automatic retire(input logic [31:0] a, input bit dbr,
                        input logic [31:0] nx, input logic [31:0] tg);
    rt_valid = 1'b1; rt_addr = a; rt_dbr = dbr; rt_next = nx; rt_target = tg;
  endtask

  task automatic dacc(input logic [31:0] a, input logic [31:0] d);
    da_valid = 1'b1; da_addr = a; da_data = d;
  endtask

  task automatic ack();
    brk_ack = 1'b1; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] base, m, fa;
    bit sl, eh;
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1: reset state and disabled unit
    expect_brk(1'b0, 32'd0, "R1 reset");
    check(brk_pc == 32'd0, "R1 reset pc", brk_pc, 32'd0);
    fetch(32'd0, 1'b0); cyc();
    expect_brk(1'b0, 32'd0, "R1 disabled fetch");

    // R3 before-execution, exact address
    wr(2'd0, 32'h1000); wr(2'd1, 32'h0); wr(2'd3, 32'h1);
    fetch(32'h1000, 1'b0); cyc();
    expect_brk(1'b1, 32'h1000, "R3 pre match");
    // R9: no second pulse while locked
    fetch(32'h1000, 1'b0); cyc();
    expect_brk(1'b0, 32'h0, "R9 locked");
    // R9: match in ack cycle ignored
    fetch(32'h1000, 1'b0); brk_ack = 1'b1; cyc();
    expect_brk(1'b0, 32'h0, "R9 ack cycle");
    fetch(32'h1000, 1'b0); cyc();
    expect_brk(1'b1, 32'h1000, "R9 after ack");
    ack();
    // R4 delay slot
    fetch(32'h1000, 1'b1); cyc();
    expect_brk(1'b1, 32'h0FFE, "R4 slot");
    ack();
    // R2 masking
    wr(2'd1, 32'hF);
    fetch(32'h100C, 1'b0); cyc();
    expect_brk(1'b1, 32'h100C, "R2 masked hit");
    ack();
    fetch(32'h1010, 1'b0); cyc();
    expect_brk(1'b0, 32'h0, "R2 outside mask");
    wr(2'd1, 32'h0);

    // R5 / R6 after-execution
    wr(2'd3, 32'h3);
    retire(32'h1000, 1'b0, 32'h1002, 32'h0); cyc();
    expect_brk(1'b1, 32'h1002, "R5 post");
    ack();
    retire(32'h1000, 1'b1, 32'h1002, 32'h2000); cyc();
    expect_brk(1'b0, 32'h0, "R6 wait slot");
    retire(32'h1002, 1'b0, 32'h1004, 32'h0); cyc();
    expect_brk(1'b1, 32'h2000, "R6 branch target");
    ack();

    // R7 data address only
    wr(2'd0, 32'h3000); wr(2'd2, 32'hDEADBEEF); wr(2'd3, 32'h5);
    dacc(32'h3000, 32'h11111111); cyc();
    expect_brk(1'b0, 32'h0, "R7 no retire yet");
    retire(32'h2344, 1'b0, 32'h2346, 32'h0); cyc();
    expect_brk(1'b1, 32'h2346, "R7 next retire");
    ack();
    dacc(32'h3000, 32'h22222222); retire(32'h23FE, 1'b0, 32'h2400, 32'h0); cyc();
    expect_brk(1'b1, 32'h2400, "R7 same cycle");
    ack();

    // R8 address plus data
    wr(2'd3, 32'h7);
    dacc(32'h3000, 32'h12345678); retire(32'h0E, 1'b0, 32'h10, 32'h0); cyc();
    expect_brk(1'b0, 32'h0, "R8 data mismatch");
    retire(32'h1E, 1'b0, 32'h20, 32'h0); cyc();
    expect_brk(1'b0, 32'h0, "R8 mismatch no pend");
    dacc(32'h3000, 32'hDEADBEEF); retire(32'h2E, 1'b0, 32'h30, 32'h0); cyc();
    expect_brk(1'b0, 32'h0, "R8 not same cycle");
    retire(32'h3E, 1'b0, 32'h40, 32'h0); cyc();
    expect_brk(1'b1, 32'h40, "R8 later retire");
    ack();

    // R10 control write clears pending; disable
    dacc(32'h3000, 32'hDEADBEEF); cyc();
    wr(2'd3, 32'h7);
    retire(32'h4E, 1'b0, 32'h50, 32'h0); cyc();
    expect_brk(1'b0, 32'h0, "R10 pending flushed");
    wr(2'd3, 32'h6);
    dacc(32'h3000, 32'hDEADBEEF); cyc();
    retire(32'h5E, 1'b0, 32'h60, 32'h0); cyc();
    expect_brk(1'b0, 32'h0, "R10 enable bit clear");

    // R2 R3 R4 random before-execution traffic
    base = 32'h0; m = 32'h0;
    for (int i = 0; i < 400; i++) begin
      if (i % 25 == 0) begin
        base = $urandom & 32'hFFFFFFFE;
        m = $urandom & 32'h3F;
        wr(2'd0, base); wr(2'd1, m); wr(2'd3, 32'h1);
      end
      fa = base ^ ($urandom & 32'hFE);
      sl = 1'($urandom & 1);
      eh = pre_hit(fa, base, m);
      fetch(fa, sl); cyc();
      expect_brk(eh, pre_pc(fa, sl), sl ? "R4 random" : "R2 R3 random");
      if (eh || brk_req) ack();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule